// File: doc/BRIEF.md
# Phase-Shiftable Symmetric PWM Channel

This block is one PWM channel. A time-base counter runs up and down between zero and a programmable peak, and one compare value drives a single output: the output goes high when the counter climbs onto the compare value and goes low when it descends onto it. The result is a center-aligned waveform whose period is twice the peak in time-base ticks. The time-base tick comes from the input clock through two cascaded power-of-two dividers, each chosen by a 3-bit code.

Several channels can run with fixed phase offsets between them. A master channel emits a one-clock pulse each time its counter arrives at zero. A slave takes that pulse on its sync input, and when phase loading is on it jumps its counter to a programmed offset on its next tick. The compare event is detected only when the counter steps onto the compare value. If a phase jump lands on or past the compare value, the rising event for that half-period is skipped on purpose. Peak and compare writes are held in shadow and take effect only when the counter arrives at zero.

Top module: `pwm_phase_gen`

## Requirements
- R1: With peak P > 0, the counter steps up by one per tick from 0 to P and then down by one per tick back to 0, so one output period is 2×P ticks. `cnt_o` never exceeds the active peak. `dir_up_o` is 1 while the next step is upward and changes to 0 on the tick that reaches P. With P = 0 the counter stays at 0 with `dir_up_o` = 1.
- R2: `pwm_o` is set to 1 on a tick where the counter steps up onto the active compare value C. It is cleared to 0 on a tick where the counter steps down onto C. It changes in the same clock that `cnt_o` shows C.
- R3: With C = P/2 and P even, `pwm_o` is high for exactly P of every 2×P consecutive ticks.
- R4: `sync_o` is high for exactly one clock, in the clock where `cnt_o` first shows 0 after a tick. It is low at all other times, including while disabled.
- R5: A `sync_i` pulse is held until the next tick. If `phs_en_i` is 1 on that tick, the counter is loaded with the smaller of `phs_i` and P. After the load it counts up, or counts down if the loaded value equals P and P > 0.
- R6: A phase load does not itself produce a compare event. With C = 100 and P = 200, a load from the falling half with phase 99 sets `pwm_o` on the next tick. A load with phase 100 or 101 leaves `pwm_o` low for that rising half.
- R7: A `sync_i` pulse that is consumed while `phs_en_i` is 0 has no effect: counting goes on as if no pulse had arrived.
- R8: A tick occurs every 2^(A+B) input clocks, where A = `div_a_i` and B = `div_b_i` are codes from 0 to 7 selecting ÷1 up to ÷128 each.
- R9: With both divider codes at 0, the counter steps on every input clock.
- R10: `prd_i` and `cmp_i` are copied into the active peak and compare on the tick where the counter arrives at 0, and continuously while disabled. A change made mid-period takes effect from the next period.
- R11: While `en_i` is 0, from the next clock on `cnt_o` is 0, `pwm_o` is 0, `dir_up_o` is 1 and the divider restarts. After `en_i` rises, the first tick comes 2^(A+B) clocks later.
- R12: After reset, `cnt_o` = 0, `pwm_o` = 0, `sync_o` = 0 and `dir_up_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable; low holds the channel idle |
| prd_i | input | CNT_W | Peak value (shadow) |
| cmp_i | input | CNT_W | Compare value (shadow) |
| phs_i | input | CNT_W | Phase offset loaded on sync |
| phs_en_i | input | 1 | Enables phase loading on sync |
| div_a_i | input | CODE_W | First divider code, ÷2^code |
| div_b_i | input | CODE_W | Second divider code, ÷2^code |
| sync_i | input | 1 | Sync pulse from a master channel |
| pwm_o | output | 1 | PWM output |
| sync_o | output | 1 | One-clock pulse when the counter arrives at zero |
| cnt_o | output | CNT_W | Time-base counter value |
| dir_up_o | output | 1 | 1 while counting up |

## Verification
The bench builds the channel with CNT_W = 8 and CODE_W = 3. The narrow counter lets random peaks up to 255 complete many full periods in a short run, and it makes the clamp of oversized phase values against the peak and the peak-equals-compare edges frequent. Random divider codes are kept to a total shift of at most 2 so that periods stay short. A directed case at codes 1 and 2 covers the ÷8 cadence, and a directed case at phases 99, 100 and 101 against compare 100 covers the dropped-event boundary.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    // largest total shift the two dividers can request
    function automatic int unsigned max_shift(input int unsigned code_w);
        return 2 * ((1 << code_w) - 1);
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] div_a_i,
    input  logic [CODE_W-1:0] div_b_i,
    output logic              tick_o
);
    import pwm_phase_pkg::*;

    localparam int unsigned SH_MAX = max_shift(CODE_W);
    localparam int unsigned PRE_W  = SH_MAX + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_st_t;

    tick_st_t st_d, st_q;

    logic [CODE_W:0]  shift;
    logic [PRE_W-1:0] limit;
    logic             tick;

    always_comb begin
        shift = {1'b0, div_a_i} + {1'b0, div_b_i};
        limit = ({{(PRE_W-1){1'b0}}, 1'b1} << shift) - {{(PRE_W-1){1'b0}}, 1'b1};
        tick  = en_i && (st_q.pre >= limit);
        st_d  = st_q;
        if (!en_i || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + {{(PRE_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] phs_i,
    input  logic             phs_en_i,
    input  logic             sync_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             sync_o,
    output logic             set_evt_o,
    output logic             clr_evt_o,
    output logic [CNT_W-1:0] prd_act_o,
    output logic [CNT_W-1:0] cmp_act_o
);
    import pwm_phase_pkg::*;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
        logic             pend;
        logic [CNT_W-1:0] prd_act;
        logic [CNT_W-1:0] cmp_act;
        logic             sync;
    } tb_st_t;

    tb_st_t st_d, st_q;

    logic             sync_now;
    logic [CNT_W-1:0] ld_val;
    logic             up_step;
    logic             dn_step;

    always_comb begin
        st_d     = st_q;
        sync_now = sync_i || st_q.pend;
        ld_val   = (phs_i > st_q.prd_act) ? st_q.prd_act : phs_i;
        up_step  = 1'b0;
        dn_step  = 1'b0;
        st_d.sync = 1'b0;

        if (!en_i) begin
            st_d.cnt     = '0;
            st_d.dir     = DIR_UP;
            st_d.pend    = 1'b0;
            st_d.prd_act = prd_i;
            st_d.cmp_act = cmp_i;
        end else if (tick_i) begin
            st_d.pend = 1'b0;
            if (sync_now && phs_en_i) begin
                st_d.cnt = ld_val;
                st_d.dir = (ld_val == st_q.prd_act && st_q.prd_act != '0) ? DIR_DOWN : DIR_UP;
            end else if (st_q.prd_act == '0) begin
                st_d.cnt = '0;
                st_d.dir = DIR_UP;
            end else if (st_q.dir == DIR_UP) begin
                if (st_q.cnt >= st_q.prd_act) begin
                    st_d.cnt = st_q.prd_act;
                    st_d.dir = DIR_DOWN;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                    up_step  = 1'b1;
                    if (st_d.cnt == st_q.prd_act) begin
                        st_d.dir = DIR_DOWN;
                    end
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.dir = DIR_UP;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                    dn_step  = 1'b1;
                    if (st_d.cnt == '0) begin
                        st_d.dir = DIR_UP;
                    end
                end
            end
            if (st_d.cnt == '0) begin
                st_d.sync    = 1'b1;
                st_d.prd_act = prd_i;
                st_d.cmp_act = cmp_i;
            end
        end else begin
            st_d.pend = st_q.pend || sync_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP, pend: 1'b0, prd_act: '0, cmp_act: '0, sync: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign dir_up_o  = (st_q.dir == DIR_UP);
    assign sync_o    = st_q.sync;
    assign set_evt_o = up_step && (st_d.cnt == st_q.cmp_act);
    assign clr_evt_o = dn_step && (st_d.cnt == st_q.cmp_act);
    assign prd_act_o = st_q.prd_act;
    assign cmp_act_o = st_q.cmp_act;

endmodule

// File: rtl/pwm_action.sv
module pwm_action (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic pwm_o
);
    typedef struct packed {
        logic lvl;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.lvl = 1'b0;
        end else if (set_i) begin
            st_d.lvl = 1'b1;
        end else if (clr_i) begin
            st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.lvl;

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  prd_i,
    input  logic [CNT_W-1:0]  cmp_i,
    input  logic [CNT_W-1:0]  phs_i,
    input  logic              phs_en_i,
    input  logic [CODE_W-1:0] div_a_i,
    input  logic [CODE_W-1:0] div_b_i,
    input  logic              sync_i,
    output logic              pwm_o,
    output logic              sync_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_up_o
);
    logic             tick;
    logic             set_evt;
    logic             clr_evt;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cmp_act;

    pwm_tick_gen #(.CODE_W(CODE_W)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .div_a_i (div_a_i),
        .div_b_i (div_b_i),
        .tick_o  (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) i_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .tick_i    (tick),
        .prd_i     (prd_i),
        .cmp_i     (cmp_i),
        .phs_i     (phs_i),
        .phs_en_i  (phs_en_i),
        .sync_i    (sync_i),
        .cnt_o     (cnt_o),
        .dir_up_o  (dir_up_o),
        .sync_o    (sync_o),
        .set_evt_o (set_evt),
        .clr_evt_o (clr_evt),
        .prd_act_o (prd_act),
        .cmp_act_o (cmp_act)
    );

    pwm_action i_act (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .set_i (set_evt),
        .clr_i (clr_evt),
        .pwm_o (pwm_o)
    );

endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             pwm_o,
    input logic             sync_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic             dir_up_o,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] cmp_act
);
    // R11: disabled channel is idle one clock later
    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_o == '0 && !pwm_o && dir_up_o));

    // R4: sync pulse only with the counter at zero
    a_r4_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (cnt_o == '0));

    // R1: counter stays within the active peak
    a_r1_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= prd_act);

    // R2: rising output edge only on the compare value
    a_r2_rise_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> (cnt_o == cmp_act));

    // R2: falling edge while enabled only on the compare value
    a_r2_fall_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_o) && $past(en_i) && cnt_o != '0) |-> (cnt_o == cmp_act));

endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .pwm_o    (pwm_o),
    .sync_o   (sync_o),
    .cnt_o    (cnt_o),
    .dir_up_o (dir_up_o),
    .prd_act  (prd_act),
    .cmp_act  (cmp_act)
);

// File: tb/test_pwm_phase_gen.sv
module test_pwm_phase_gen;
    localparam int CW = 8;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b0;
    logic [CW-1:0] prd_i = '0;
    logic [CW-1:0] cmp_i = '0;
    logic [CW-1:0] phs_i = '0;
    logic          phs_en_i = 1'b0;
    logic [KW-1:0] div_a_i = '0;
    logic [KW-1:0] div_b_i = '0;
    logic          sync_i = 1'b0;
    logic          pwm_o;
    logic          sync_o;
    logic [CW-1:0] cnt_o;
    logic          dir_up_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_phase_gen #(.CNT_W(CW), .CODE_W(KW)) i_pwm_phase_gen (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .prd_i(prd_i), .cmp_i(cmp_i),
        .phs_i(phs_i), .phs_en_i(phs_en_i), .div_a_i(div_a_i), .div_b_i(div_b_i),
        .sync_i(sync_i), .pwm_o(pwm_o), .sync_o(sync_o), .cnt_o(cnt_o), .dir_up_o(dir_up_o)
    );

    // reference state built from the requirements
    int m_pre, m_cnt, m_prd, m_cmp;
    bit m_up, m_pend, m_pwm, m_sync;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_prd = 0; m_cmp = 0;
            m_up = 1; m_pend = 0; m_pwm = 0; m_sync = 0;
        end else begin
            automatic int lim = (1 << (div_a_i + div_b_i)) - 1;
            automatic bit tk = en_i && (m_pre >= lim);
            automatic int nc = m_cnt;
            automatic bit nu = m_up;
            automatic bit us = 0;
            automatic bit ds = 0;
            automatic int ld;
            m_sync = 0;
            if (!en_i) begin
                m_pre = 0; m_cnt = 0; m_up = 1; m_pend = 0; m_pwm = 0;
                m_prd = prd_i; m_cmp = cmp_i;
            end else if (tk) begin
                m_pre = 0;
                if ((sync_i || m_pend) && phs_en_i) begin
                    ld = (phs_i > m_prd) ? m_prd : phs_i;
                    nc = ld;
                    nu = !(ld == m_prd && m_prd != 0);
                end else if (m_prd == 0) begin
                    nc = 0; nu = 1;
                end else if (m_up) begin
                    nc = m_cnt + 1; us = 1;
                    if (nc == m_prd) nu = 0;
                end else begin
                    nc = m_cnt - 1; ds = 1;
                    if (nc == 0) nu = 1;
                end
                if (us && nc == m_cmp) m_pwm = 1;
                if (ds && nc == m_cmp) m_pwm = 0;
                m_pend = 0;
                m_cnt = nc; m_up = nu;
                if (nc == 0) begin
                    m_sync = 1; m_prd = prd_i; m_cmp = cmp_i;
                end
            end else begin
                m_pre = m_pre + 1;
                m_pend = m_pend || sync_i;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: wait for the falling edge, compare all outputs to the reference
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk(cnt_o == m_cnt[CW-1:0], "R1 cnt", cnt_o, m_cnt);
            chk(dir_up_o == m_up, "R1 dir", dir_up_o, m_up);
            chk(pwm_o == m_pwm, "R2 pwm", pwm_o, m_pwm);
            chk(sync_o == m_sync, "R4 sync", sync_o, m_sync);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic setup(input int p, input int c, input int a, input int b);
        prd_i = p[CW-1:0]; cmp_i = c[CW-1:0];
        div_a_i = a[KW-1:0]; div_b_i = b[KW-1:0];
        en_i = 0; step(); en_i = 1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int prev, gap, mx, hi;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(cnt_o == 0, "R12 cnt", cnt_o, 0);
        chk(pwm_o == 0, "R12 pwm", pwm_o, 0);
        chk(sync_o == 0, "R12 sync", sync_o, 0);
        chk(dir_up_o == 1, "R12 dir", dir_up_o, 1);

        // R9 one step per clock with codes 0
        setup(10, 5, 0, 0);
        step();
        chk(cnt_o == 1, "R9 first", cnt_o, 1);
        step();
        chk(cnt_o == 2, "R9 second", cnt_o, 2);

        // R3 duty and R4 single sync pulse
        for (int i = 0; i < 40 && !sync_o; i++) step();
        chk(cnt_o == 0, "R4 at zero", cnt_o, 0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (i == 0) chk(sync_o == 0, "R4 width", sync_o, 0);
            hi += pwm_o;
        end
        chk(hi == 10, "R3 duty", hi, 10);

        // R8 divide by 2^(1+2)
        setup(200, 100, 1, 2);
        run(20);
        prev = cnt_o;
        for (int i = 0; i < 40 && cnt_o == prev; i++) step();
        prev = cnt_o; gap = 0;
        for (int i = 0; i < 40 && cnt_o == prev; i++) begin step(); gap++; end
        chk(gap == 8, "R8 cadence", gap, 8);

        // R11 disable
        en_i = 0; step();
        chk(cnt_o == 0 && pwm_o == 0 && dir_up_o == 1, "R11 idle", cnt_o, 0);

        // R10 shadowed peak change
        setup(10, 5, 0, 0);
        for (int i = 0; i < 20 && !(cnt_o == 3 && dir_up_o); i++) step();
        prd_i = 20;
        mx = 0;
        for (int i = 0; i < 30 && !(cnt_o == 0 && i > 0); i++) begin
            step(); if (cnt_o > mx) mx = cnt_o;
        end
        chk(mx == 10, "R10 old peak", mx, 10);
        mx = 0;
        for (int i = 0; i < 50; i++) begin
            step(); if (cnt_o > mx) mx = cnt_o;
        end
        chk(mx == 20, "R10 new peak", mx, 20);

        // R6 phase at, above and below the compare value; R5 load
        for (int k = 99; k <= 101; k++) begin
            setup(200, 100, 0, 0);
            phs_en_i = 1;
            for (int i = 0; i < 600 && !(cnt_o == 50 && !dir_up_o); i++) step();
            phs_i = k[CW-1:0]; sync_i = 1; step(); sync_i = 0;
            chk(cnt_o == k, "R5 load", cnt_o, k);
            chk(dir_up_o == 1, "R5 up after load", dir_up_o, 1);
            run(59);
            chk(pwm_o == (k < 100), "R6 event", pwm_o, (k < 100));
        end

        // R7 sync ignored without phase enable
        phs_en_i = 0; phs_i = 7;
        prev = cnt_o;
        sync_i = 1; step(); sync_i = 0;
        chk(cnt_o == prev + 1, "R7 ignored", cnt_o, prev + 1);

        // R5 clamp of an oversized phase
        setup(30, 10, 0, 0);
        phs_en_i = 1; phs_i = 90; run(5);
        sync_i = 1; step(); sync_i = 0;
        chk(cnt_o == 30 && dir_up_o == 0, "R5 clamp", cnt_o, 30);

        // constrained random segments
        for (int s = 0; s < 60; s++) begin
            automatic int p = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 255);
            automatic int a = $urandom_range(0, 1);
            automatic int b = $urandom_range(0, 1);
            prd_i = p[CW-1:0];
            cmp_i = $urandom_range(0, 255) % (p + 1);
            div_a_i = a[KW-1:0]; div_b_i = b[KW-1:0];
            phs_en_i = $urandom_range(0, 1);
            en_i = 1;
            for (int i = 0; i < 600; i++) begin
                sync_i = ($urandom_range(0, 49) == 0);
                phs_i = $urandom_range(0, 255);
                if ($urandom_range(0, 199) == 0) prd_i = $urandom_range(1, 255);
                if ($urandom_range(0, 199) == 0) cmp_i = $urandom_range(0, 255);
                en_i = ($urandom_range(0, 399) != 0);
                step();
            end
            sync_i = 0;
        end
        summary();
    end
endmodule